// File: doc/BRIEF.md
# Stack Machine Address Register Unit

This unit holds the four pointer registers of a small stack-based CPU datapath. Two of them, A and B, are walking pointers. A fetch or store through one of them can leave the pointer where it is, or step it by one cell after the access. The other two, X and Y, are base registers. An access through one of them goes to the base plus a signed literal, and the base register does not move. Each register can also be loaded from the top-of-stack value and copied back to the stack.

In each cycle the decoder supplies an operation code, a register select, the top-of-stack value and an 8-bit literal. The unit registers a single-port memory request: request, write enable, address and write data. One cycle after the operation is sampled, it returns a result for the data stack with a valid strobe. That result is either a register copy or the word the memory returns for the registered address. The memory is expected to present read data combinationally from the registered address.

A build option makes B write-only. In that build, an attempt to copy B to the stack raises a one-cycle error flag and does nothing else.

Top module: `addr_reg_unit`

## Requirements
- R1: After reset, A, B, X and Y are all zero, and mem_req_o, stk_valid_o and err_o are low.
- R2: Op code 1 (load) writes tos_i into the register chosen by sel_i (0=A, 1=B, 2=X, 3=Y). Op code 2 (read) returns that register's value on stk_data_o with stk_valid_o high in the cycle after the op is sampled.
- R3: Op code 3 (fetch) and op code 6 (store) access the address held in A (sel_i[0]=0) or B (sel_i[0]=1) and leave that pointer unchanged. A store asserts mem_we_o with mem_wdata_o equal to tos_i.
- R4: Op code 4 (fetch with step up) reads at the pointer, then adds one cell (4 address units) to the pointer.
- R5: Op code 5 (fetch with step down) reads at the pointer, then subtracts 4 from the pointer.
- R6: Op code 7 (store with step up) writes tos_i at the pointer, then adds 4 to the pointer.
- R7: Op code 8 (indexed fetch) and op code 9 (indexed store) use the address X (sel_i[0]=0) or Y (sel_i[0]=1) plus ofs_i, where ofs_i is sign-extended from 8 bits. X and Y are not modified.
- R8: For every fetch, in the cycle after the op is sampled, stk_valid_o is high and stk_data_o equals the word the memory holds at the requested address, including a word stored by the previous operation.
- R9: When B_WRITE_ONLY=1, a read of B (op 2, sel_i=1) raises err_o for one cycle, gives no stk_valid_o and changes no register. When B_WRITE_ONLY=0, err_o never rises.
- R10: Op codes 0, 1 and 2, and the unused codes 10 to 15, issue no memory request. The unused codes change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 4 | Operation code |
| sel_i | input | 2 | Register select; bit 0 picks A/B or X/Y for memory ops |
| tos_i | input | DATA_W | Top-of-stack value |
| ofs_i | input | OFS_W | Signed literal offset for indexed ops |
| mem_req_o | output | 1 | Registered memory request |
| mem_we_o | output | 1 | Registered write enable |
| mem_addr_o | output | DATA_W | Registered byte address |
| mem_wdata_o | output | DATA_W | Registered write data |
| mem_rdata_i | input | DATA_W | Memory read data for the registered address |
| stk_valid_o | output | 1 | Result for the data stack is valid |
| stk_data_o | output | DATA_W | Result for the data stack |
| err_o | output | 1 | Illegal read of write-only B |

## Verification
On every cycle, the assertions check the pointer arithmetic and the address that each access type issues. They also check that base registers hold still on indexed accesses, that ops without memory traffic raise no request, and that the error flag never coincides with a stack result. Only the bench scenarios can show the round trip through memory: a stored word coming back on a later fetch, a negative literal reaching below a base, and a chain of stepped accesses whose final pointer is read back. The write-only B option is exercised on a second instance driven with the same stream.

// File: rtl/addr_reg_pkg.sv
package addr_reg_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_LOAD      = 4'd1,
    OP_READ      = 4'd2,
    OP_FETCH     = 4'd3,
    OP_FETCH_INC = 4'd4,
    OP_FETCH_DEC = 4'd5,
    OP_STORE     = 4'd6,
    OP_STORE_INC = 4'd7,
    OP_IDX_FETCH = 4'd8,
    OP_IDX_STORE = 4'd9
  } op_e;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned REG_A = 0;
  localparam int unsigned REG_B = 1;
  localparam int unsigned REG_X = 2;
  localparam int unsigned REG_Y = 3;
endpackage

// File: rtl/addr_reg_bank.sv
module addr_reg_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREG   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0]             wr_en_i,
  input  logic [NREG-1:0][DATA_W-1:0] wr_data_i,
  output logic [NREG-1:0][DATA_W-1:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_o[g] <= '0;
      end else if (wr_en_i[g]) begin
        q_o[g] <= wr_data_i[g];
      end
    end
  end
endmodule

// File: rtl/addr_calc.sv
module addr_calc #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFS_W      = 8,
  parameter int unsigned CELL_BYTES = 4
) (
  input  logic [DATA_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [DATA_W-1:0] inc_o,
  output logic [DATA_W-1:0] dec_o,
  output logic [DATA_W-1:0] idx_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(CELL_BYTES);
  logic [DATA_W-1:0] ofs_ext;

  always_comb begin
    ofs_ext = {{(DATA_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    inc_o   = ptr_i + STEP;
    dec_o   = ptr_i - STEP;
    idx_o   = base_i + ofs_ext;
  end
endmodule

// File: rtl/addr_reg_unit.sv
module addr_reg_unit
  import addr_reg_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned OFS_W        = 8,
  parameter int unsigned CELL_BYTES   = 4,
  parameter bit          B_WRITE_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] tos_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              stk_valid_o,
  output logic [DATA_W-1:0] stk_data_o,
  output logic              err_o
);
  localparam int unsigned NREG = NUM_REGS;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NREG-1:0]             wr_en;
  logic [NREG-1:0][DATA_W-1:0] wr_data;
  logic [NREG-1:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0]           ptr, base, ptr_inc, ptr_dec, idx_addr;
  logic [0:0]                  ab_idx;

  assign ab_idx = sel_i[0];
  assign ptr    = sel_i[0] ? reg_q[REG_B] : reg_q[REG_A];
  assign base   = sel_i[0] ? reg_q[REG_Y] : reg_q[REG_X];

  addr_calc #(.DATA_W(DATA_W), .OFS_W(OFS_W), .CELL_BYTES(CELL_BYTES)) u_calc (
    .ptr_i (ptr),
    .base_i(base),
    .ofs_i (ofs_i),
    .inc_o (ptr_inc),
    .dec_o (ptr_dec),
    .idx_o (idx_addr)
  );

  addr_reg_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .q_o      (reg_q)
  );

  logic              req_d, we_d, fetch_d, rd_d, err_d;
  logic [DATA_W-1:0] addr_d, wdata_d, rdval_d;
  op_e               op;

  always_comb begin
    op      = op_e'(op_i);
    wr_en   = '0;
    wr_data = reg_q;
    req_d   = 1'b0;
    we_d    = 1'b0;
    fetch_d = 1'b0;
    rd_d    = 1'b0;
    err_d   = 1'b0;
    addr_d  = ptr;
    wdata_d = tos_i;
    rdval_d = reg_q[sel_i];
    case (op)
      OP_LOAD: begin
        wr_en[sel_i]   = 1'b1;
        wr_data[sel_i] = tos_i;
      end
      OP_READ: begin
        if (B_WRITE_ONLY && sel_i == 2'(REG_B)) err_d = 1'b1;
        else                                   rd_d  = 1'b1;
      end
      OP_FETCH: begin
        req_d   = 1'b1;
        fetch_d = 1'b1;
      end
      OP_FETCH_INC: begin
        req_d           = 1'b1;
        fetch_d         = 1'b1;
        wr_en[ab_idx]   = 1'b1;
        wr_data[ab_idx] = ptr_inc;
      end
      OP_FETCH_DEC: begin
        req_d           = 1'b1;
        fetch_d         = 1'b1;
        wr_en[ab_idx]   = 1'b1;
        wr_data[ab_idx] = ptr_dec;
      end
      OP_STORE: begin
        req_d = 1'b1;
        we_d  = 1'b1;
      end
      OP_STORE_INC: begin
        req_d           = 1'b1;
        we_d            = 1'b1;
        wr_en[ab_idx]   = 1'b1;
        wr_data[ab_idx] = ptr_inc;
      end
      OP_IDX_FETCH: begin
        req_d   = 1'b1;
        fetch_d = 1'b1;
        addr_d  = idx_addr;
      end
      OP_IDX_STORE: begin
        req_d  = 1'b1;
        we_d   = 1'b1;
        addr_d = idx_addr;
      end
      default: ;
    endcase
  end

  logic              fetch_q, rd_q;
  logic [DATA_W-1:0] rdval_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_req_o <= 1'b0;
      mem_we_o  <= 1'b0;
      fetch_q   <= 1'b0;
      rd_q      <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      mem_req_o <= req_d;
      mem_we_o  <= we_d;
      fetch_q   <= fetch_d;
      rd_q      <= rd_d;
      err_o     <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (req_d) begin
      mem_addr_o  <= addr_d;
      mem_wdata_o <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdval_q <= '0;
    else if (rd_d)   rdval_q <= rdval_d;
  end

  assign stk_valid_o = fetch_q | rd_q;
  assign stk_data_o  = fetch_q ? mem_rdata_i : rdval_q;
endmodule

// File: rtl/addr_reg_unit_chk.sv
module addr_reg_unit_chk #(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned CELL_BYTES   = 4,
  parameter bit          B_WRITE_ONLY = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] tos_i,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic [DATA_W-1:0] x_q,
  input logic [DATA_W-1:0] y_q,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              stk_valid_o,
  input logic              err_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(CELL_BYTES);

  // R1
  reset_clear_chk: assert property (@(posedge clk) $rose(rst_n) |->
    (a_q == '0 && b_q == '0 && x_q == '0 && y_q == '0 && !mem_req_o && !err_o));

  // R10
  no_traffic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op_i) <= 4'd2 || $past(op_i) >= 4'd10)) |-> !mem_req_o);

  // R3
  plain_fetch_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 4'd3 && !$past(sel_i[0])) |->
    (mem_req_o && !mem_we_o && mem_addr_o == $past(a_q) && a_q == $past(a_q)));

  // R4
  fetch_up_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 4'd4 && !$past(sel_i[0])) |->
    (mem_addr_o == $past(a_q) && a_q == $past(a_q) + STEP));

  // R5
  fetch_down_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 4'd5 && $past(sel_i[0])) |->
    (mem_addr_o == $past(b_q) && b_q == $past(b_q) - STEP));

  // R6
  store_up_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_i) == 4'd7 && $past(sel_i[0])) |->
    (mem_we_o && mem_wdata_o == $past(tos_i) && b_q == $past(b_q) + STEP));

  // R7
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(op_i) == 4'd8 || $past(op_i) == 4'd9)) |->
    (mem_req_o && $stable(x_q) && $stable(y_q)));

  // R9
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!stk_valid_o && B_WRITE_ONLY));

  // R3
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_req_o);
endmodule

bind addr_reg_unit addr_reg_unit_chk #(
  .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .B_WRITE_ONLY(B_WRITE_ONLY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .op_i       (op_i),
  .sel_i      (sel_i),
  .tos_i      (tos_i),
  .a_q        (reg_q[0]),
  .b_q        (reg_q[1]),
  .x_q        (reg_q[2]),
  .y_q        (reg_q[3]),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .stk_valid_o(stk_valid_o),
  .err_o      (err_o)
);

// File: tb/addr_reg_unit_tb.sv
module addr_reg_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] tos = '0;
  logic [7:0]  ofs = '0;
  logic        mem_req, mem_we, stk_valid, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, stk_data;
  logic        wo_req, wo_we, wo_valid, wo_err;
  logic [31:0] wo_addr, wo_wdata, wo_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_reg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .sel_i(sel), .tos_i(tos), .ofs_i(ofs),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .stk_valid_o(stk_valid), .stk_data_o(stk_data), .err_o(err)
  );

  addr_reg_unit #(.B_WRITE_ONLY(1'b1)) u_dut_wo (
    .clk(clk), .rst_n(rst_n), .op_i(op), .sel_i(sel), .tos_i(tos), .ofs_i(ofs),
    .mem_req_o(wo_req), .mem_we_o(wo_we), .mem_addr_o(wo_addr),
    .mem_wdata_o(wo_wdata), .mem_rdata_i(mem_rdata),
    .stk_valid_o(wo_valid), .stk_data_o(wo_data), .err_o(wo_err)
  );

  // memory model: write at the edge after the request, combinational read
  logic [31:0] mem [256];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + 32'(i);
    end else if (mem_we) begin
      mem[mem_addr[9:2]] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr[9:2]];

  typedef struct {
    int          due;
    string       tag;
    logic        valid;
    logic [31:0] data;
    logic        req;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        wo_err;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  logic [31:0] m_reg [4];
  logic [31:0] sh_mem [256];
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      bit   ok;
      e  = sb.pop_front();
      ok = (stk_valid == e.valid) && (!e.valid || stk_data == e.data) &&
           (mem_req == e.req) && (mem_we == e.we) &&
           (!e.req || mem_addr == e.addr) && (!e.we || mem_wdata == e.wdata) &&
           (err == 1'b0) && (wo_err == e.wo_err) &&
           (wo_valid == (e.valid && !e.wo_err));
      check(e.tag, ok,
        $sformatf("v=%0b d=%h req=%0b we=%0b a=%h wd=%h err=%0b woerr=%0b wov=%0b",
                  stk_valid, stk_data, mem_req, mem_we, mem_addr, mem_wdata, err, wo_err, wo_valid),
        $sformatf("v=%0b d=%h req=%0b we=%0b a=%h wd=%h err=0 woerr=%0b wov=%0b",
                  e.valid, e.data, e.req, e.we, e.addr, e.wdata, e.wo_err, e.valid && !e.wo_err));
    end
  end

  // driver with reference model
  task automatic do_op(input logic [3:0] o, input logic [1:0] s, input logic [31:0] t,
                       input logic [7:0] f, input string tag);
    exp_t        e;
    logic [31:0] a;
    int          ab;
    @(negedge clk); #1;
    op = o; sel = s; tos = t; ofs = f;
    e.due = cyc + 1; e.tag = tag;
    e.valid = 0; e.data = '0; e.req = 0; e.we = 0; e.addr = '0; e.wdata = '0; e.wo_err = 0;
    ab = s[0] ? 1 : 0;
    case (o)
      4'd1: m_reg[s] = t;
      4'd2: begin e.valid = 1; e.data = m_reg[s]; e.wo_err = (s == 2'd1); end
      4'd3, 4'd4, 4'd5: begin
        a = m_reg[ab];
        e.req = 1; e.addr = a; e.valid = 1; e.data = sh_mem[a[9:2]];
        if (o == 4'd4) m_reg[ab] = a + 32'd4;
        if (o == 4'd5) m_reg[ab] = a - 32'd4;
      end
      4'd6, 4'd7: begin
        a = m_reg[ab];
        e.req = 1; e.we = 1; e.addr = a; e.wdata = t; sh_mem[a[9:2]] = t;
        if (o == 4'd7) m_reg[ab] = a + 32'd4;
      end
      4'd8, 4'd9: begin
        a = m_reg[2 + ab] + {{24{f[7]}}, f};
        e.req = 1; e.addr = a;
        if (o == 4'd8) begin e.valid = 1; e.data = sh_mem[a[9:2]]; end
        else begin e.we = 1; e.wdata = t; sh_mem[a[9:2]] = t; end
      end
      default: ;
    endcase
    sb.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) sh_mem[i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle after reset
    check("R1", !stk_valid && !mem_req && !err && !wo_err,
          $sformatf("v=%0b req=%0b err=%0b", stk_valid, mem_req, err), "all zero");
    // R1: registers read back as zero
    do_op(4'd2, 2'd0, 0, 0, "R1");
    do_op(4'd2, 2'd2, 0, 0, "R1");
    do_op(4'd2, 2'd3, 0, 0, "R1");
    // R2: load and read back
    do_op(4'd1, 2'd0, 32'h100, 0, "R2");
    do_op(4'd1, 2'd1, 32'h200, 0, "R2");
    do_op(4'd1, 2'd2, 32'h040, 0, "R2");
    do_op(4'd1, 2'd3, 32'h080, 0, "R2");
    do_op(4'd2, 2'd0, 0, 0, "R2");
    do_op(4'd2, 2'd2, 0, 0, "R2");
    do_op(4'd2, 2'd3, 0, 0, "R2");
    // R3: plain fetch and store leave pointers in place
    do_op(4'd3, 2'd0, 0, 0, "R3");
    do_op(4'd2, 2'd0, 0, 0, "R3");
    do_op(4'd6, 2'd1, 32'hDEAD_BEEF, 0, "R3");
    do_op(4'd3, 2'd1, 0, 0, "R8");
    // R4: stepping up twice
    do_op(4'd4, 2'd0, 0, 0, "R4");
    do_op(4'd4, 2'd0, 0, 0, "R4");
    do_op(4'd2, 2'd0, 0, 0, "R4");
    // R5: stepping down
    do_op(4'd5, 2'd1, 0, 0, "R5");
    do_op(4'd5, 2'd1, 0, 0, "R5");
    do_op(4'd1, 2'd1, 32'h1F8, 0, "R5");
    // R6: store then step up, then read back through A
    do_op(4'd7, 2'd0, 32'h1234_5678, 0, "R6");
    do_op(4'd7, 2'd0, 32'h0BAD_F00D, 0, "R6");
    do_op(4'd2, 2'd0, 0, 0, "R6");
    do_op(4'd1, 2'd0, 32'h108, 0, "R6");
    do_op(4'd3, 2'd0, 0, 0, "R8");
    // R7: indexed with positive and negative literal
    do_op(4'd8, 2'd0, 0, 8'h08, "R7");
    do_op(4'd8, 2'd1, 0, 8'hFC, "R7");
    do_op(4'd8, 2'd1, 0, 8'h80, "R7");
    do_op(4'd9, 2'd1, 32'hCAFE_0001, 8'h10, "R7");
    do_op(4'd8, 2'd1, 0, 8'h10, "R8");
    do_op(4'd2, 2'd2, 0, 0, "R7");
    do_op(4'd2, 2'd3, 0, 0, "R7");
    // R10: no traffic from idle or unused codes
    do_op(4'd0, 2'd0, 32'hFFFF_FFFF, 0, "R10");
    do_op(4'd15, 2'd0, 32'hFFFF_FFFF, 0, "R10");
    do_op(4'd12, 2'd1, 32'hFFFF_FFFF, 0, "R10");
    do_op(4'd2, 2'd0, 0, 0, "R10");
    // R9: read of B on the write-only build
    do_op(4'd2, 2'd1, 0, 0, "R9");
    do_op(4'd2, 2'd1, 0, 0, "R9");
    do_op(4'd0, 2'd0, 0, 0, "R9");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", sb.size() == 0, $sformatf("%0d pending", sb.size()), "0 pending");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule